// File: doc/BRIEF.md
# Cipher Data Buffer and Start Control

This block is the register front end of a block cipher engine. Software or a DMA channel reaches a 128-bit data block through one 32-bit data port. A 2-bit word pointer picks which of the four words an access touches, and it steps forward after every access. The same four words hold the plaintext going in and the result coming out, so a finished operation replaces the words that were loaded. The cipher core behind the block is abstract. The front end gives it the block, the initialization vector and the configuration, raises a one-cycle request, and waits for a done pulse that carries the result.

Processing can start in two ways. In manual mode it starts on a command write. In automatic mode it starts by itself once a full block of data words has been written, which suits a DMA channel that only feeds the data port. A configuration lock keeps the mode and key settings fixed while the engine is enabled. A last-output mode changes which kind of data access clears the completion flag.

The sequencer has four states. IDLE accepts accesses. LAUNCH holds the request to the core for one cycle. WAIT waits for the core's done pulse and captures the result into the buffer. FINISH sets the completion flag. The transitions are: IDLE to LAUNCH on an accepted start, LAUNCH to WAIT always, WAIT to FINISH on core done, and FINISH to IDLE always. The block counts as busy in every state except IDLE.

Top module: `cipher_frontend`

## Requirements
- R1: After reset the config register (address 0), the status register (address 2), the pointer (address 3) and all four data words read 0, and the block is not busy.
- R2: Address 4 is the data port. A read or a write there touches word `ptr`, then `ptr` becomes (`ptr`+1) mod 4. A write to address 3 loads `ptr` from bits [1:0], and address 3 reads `ptr` back. Data word 0 occupies bits [31:0] of the block sent to the core, and word 3 occupies bits [127:96].
- R3: While busy, a data port read returns 0, and a data port write changes neither the buffer nor the pointer.
- R4: In manual mode (config bit 1 = 0), writing address 1 with bit 0 set starts processing only if enable (config bit 0) is 1 and the block is idle. In automatic mode, or while disabled, that write starts nothing.
- R5: In automatic mode with enable set, processing starts on the fourth accepted data write counted since the last start or the last pointer write. Writing the pointer resets the count.
- R6: When the core finishes, its result replaces all four buffer words. After that, the data port reads back the result words.
- R7: Config layout: bit 0 enable, bit 1 automatic start, bit 2 last-output mode, bit 3 decrypt, bits [6:4] mode, bits [8:7] key size. While enable is 1, a config write changes only bit 0. While enable is 0, a config write updates all nine bits.
- R8: Writing address 1 with bit 1 set marks the next started block to use the initialization vector. That block's request carries the flag, and the flag is then cleared. Addresses 8 to 11 write IV words 0 to 3, and reading them returns 0.
- R9: Status bit 0 is the completion flag and bit 1 is busy. The flag is set when an operation finishes. It is cleared by writing 1 to status bit 0, or by an accepted manual start.
- R10: With last-output mode off, an accepted data read clears the completion flag. With it on, an accepted data write clears the flag and a data read leaves it unchanged.
- R11: Each start gives exactly one single-cycle core request. The request comes only from the idle state and carries the current buffer contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational from address) |
| busy_o | output | 1 | Operation in progress |
| done_flag_o | output | 1 | Completion flag |
| core_req | output | 1 | One-cycle start request to the cipher core |
| core_use_iv | output | 1 | Current block must use the IV |
| core_decrypt | output | 1 | Direction setting |
| core_mode | output | 3 | Chaining mode setting |
| core_keysz | output | 2 | Key size setting |
| core_block_in | output | 128 | Data block to the core |
| core_iv | output | 128 | Initialization vector to the core |
| core_done | input | 1 | Core finished, result valid |
| core_block_out | input | 128 | Result block from the core |

## Verification
The bench sweeps every pointer start position with full write and read-back passes, so a pointer that failed to wrap or that stepped on the wrong access would put words in rotated places. It probes the data port in the middle of an operation. A design without read-as-zero would leak buffer contents there, and one that accepted writes while busy would corrupt the result or leave the pointer displaced. Automatic start is driven with short bursts and pointer rewrites in between, to catch a count that does not reset or that starts one word early. Config writes while enabled, IV marking across two starts, and both flag-clearing rules under last-output mode catch a leaky lock, a sticky IV flag, or a flag cleared by the wrong kind of access.

// File: rtl/cfe_pkg.sv
package cfe_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LAUNCH,
        ST_WAIT,
        ST_FINISH
    } seq_state_t;

    typedef struct packed {
        logic [1:0] keysz;
        logic [2:0] mode;
        logic       decrypt;
        logic       last_out;
        logic       auto_start;
        logic       enable;
    } cfg_t;

    localparam int CFG_W       = 9;
    localparam int ADR_CONFIG  = 0;
    localparam int ADR_COMMAND = 1;
    localparam int ADR_STATUS  = 2;
    localparam int ADR_POINTER = 3;
    localparam int ADR_DATA    = 4;
    localparam int ADR_IV_BASE = 8;

endpackage

// File: rtl/cfe_cfg_regs.sv
module cfe_cfg_regs
    import cfe_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             cmd_fresh,
    input  logic             flag_wclr,
    input  logic             go_accept,
    input  logic             data_rd_acc,
    input  logic             data_wr_acc,
    input  logic             launch,
    input  logic             finish,
    output cfg_t             cfg,
    output logic             done_flag,
    output logic             fresh_pending
);

    logic flag_clear;

    always_comb begin
        flag_clear = flag_wclr
                   || go_accept
                   || (data_rd_acc && !cfg.last_out)
                   || (data_wr_acc &&  cfg.last_out);
    end

    // Configuration: only the enable bit is writable while enabled
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (cfg_we) begin
            if (cfg.enable) begin
                cfg.enable <= cfg_wdata[0];
            end else begin
                cfg <= cfg_t'(cfg_wdata);
            end
        end
    end

    // IV marker for the next launched block
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fresh_pending <= 1'b0;
        end else if (launch) begin
            fresh_pending <= 1'b0;
        end else if (cmd_fresh) begin
            fresh_pending <= 1'b1;
        end
    end

    // Completion flag: setting wins over clearing
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_flag <= 1'b0;
        end else if (finish) begin
            done_flag <= 1'b1;
        end else if (flag_clear) begin
            done_flag <= 1'b0;
        end
    end

endmodule

// File: rtl/cfe_word_buffer.sv
module cfe_word_buffer #(
    parameter int WORD_W    = 32,
    parameter int NUM_WORDS = 4,
    localparam int PTR_W    = $clog2(NUM_WORDS),
    localparam int BLK_W    = WORD_W * NUM_WORDS,
    localparam int CNT_W    = $clog2(NUM_WORDS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ptr_we,
    input  logic [PTR_W-1:0]  ptr_wdata,
    input  logic              acc_rd,
    input  logic              acc_wr,
    input  logic [WORD_W-1:0] wdata,
    input  logic              count_en,
    input  logic              count_clear,
    input  logic              load_result,
    input  logic [BLK_W-1:0]  result,
    output logic [WORD_W-1:0] rd_word,
    output logic [PTR_W-1:0]  ptr,
    output logic [BLK_W-1:0]  block,
    output logic              fill_done
);

    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(NUM_WORDS - 1);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(NUM_WORDS - 1);

    logic [WORD_W-1:0] mem [NUM_WORDS];
    logic [CNT_W-1:0]  wr_cnt;

    // Storage: result load has priority over port writes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_WORDS; i++) begin
                mem[i] <= '0;
            end
        end else begin
            for (int i = 0; i < NUM_WORDS; i++) begin
                if (load_result) begin
                    mem[i] <= result[i*WORD_W +: WORD_W];
                end else if (acc_wr && (ptr == PTR_W'(i))) begin
                    mem[i] <= wdata;
                end
            end
        end
    end

    // Word pointer: direct load, else step with wrap
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (ptr_we) begin
            ptr <= ptr_wdata;
        end else if (acc_rd || acc_wr) begin
            ptr <= (ptr == LAST_PTR) ? '0 : ptr + 1'b1;
        end
    end

    // Fill counter for automatic start
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_cnt <= '0;
        end else if (count_clear) begin
            wr_cnt <= '0;
        end else if (acc_wr && count_en) begin
            wr_cnt <= wr_cnt + 1'b1;
        end
    end

    always_comb begin
        fill_done = acc_wr && count_en && (wr_cnt == LAST_CNT);
        rd_word   = mem[ptr];
    end

    generate
        for (genvar g = 0; g < NUM_WORDS; g++) begin : g_block
            assign block[g*WORD_W +: WORD_W] = mem[g];
        end
    endgenerate

endmodule

// File: rtl/cfe_seq_fsm.sv
module cfe_seq_fsm
    import cfe_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_req,
    input  logic core_done,
    output logic busy,
    output logic launch,
    output logic capture,
    output logic finish
);

    seq_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_req) state_d = ST_LAUNCH;
            ST_LAUNCH: state_d = ST_WAIT;
            ST_WAIT:   if (core_done) state_d = ST_FINISH;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        busy    = 1'b1;
        launch  = 1'b0;
        capture = 1'b0;
        finish  = 1'b0;
        unique case (state_q)
            ST_IDLE:   busy = 1'b0;
            ST_LAUNCH: launch = 1'b1;
            ST_WAIT:   capture = core_done;
            ST_FINISH: finish = 1'b1;
            default:   busy = 1'b0;
        endcase
    end

endmodule

// File: rtl/cipher_frontend.sv
module cipher_frontend
    import cfe_pkg::*;
#(
    parameter int WORD_W    = 32,
    parameter int NUM_WORDS = 4,
    parameter int ADDR_W    = 4,
    localparam int PTR_W    = $clog2(NUM_WORDS),
    localparam int BLK_W    = WORD_W * NUM_WORDS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    output logic              busy_o,
    output logic              done_flag_o,
    output logic              core_req,
    output logic              core_use_iv,
    output logic              core_decrypt,
    output logic [2:0]        core_mode,
    output logic [1:0]        core_keysz,
    output logic [BLK_W-1:0]  core_block_in,
    output logic [BLK_W-1:0]  core_iv,
    input  logic              core_done,
    input  logic [BLK_W-1:0]  core_block_out
);

    cfg_t              cfg;
    logic              cfg_enable;
    logic              busy, launch, capture, finish;
    logic              fresh_pending;
    logic              sel_cfg, sel_cmd, sel_stat, sel_ptr, sel_data;
    logic              acc_rd, acc_wr, go_accept, count_en, fill_done;
    logic [WORD_W-1:0] rd_word;
    logic [PTR_W-1:0]  ptr;
    logic [WORD_W-1:0] iv_mem [NUM_WORDS];

    always_comb begin
        sel_cfg   = (bus_addr == ADDR_W'(ADR_CONFIG));
        sel_cmd   = (bus_addr == ADDR_W'(ADR_COMMAND));
        sel_stat  = (bus_addr == ADDR_W'(ADR_STATUS));
        sel_ptr   = (bus_addr == ADDR_W'(ADR_POINTER));
        sel_data  = (bus_addr == ADDR_W'(ADR_DATA));
        acc_rd    = bus_rd && sel_data && !busy;
        acc_wr    = bus_wr && sel_data && !busy;
        go_accept = bus_wr && sel_cmd && bus_wdata[0]
                    && cfg.enable && !cfg.auto_start && !busy;
        count_en  = cfg.enable && cfg.auto_start && !busy;
        cfg_enable = cfg.enable;
    end

    cfe_cfg_regs u_regs (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_we        (bus_wr && sel_cfg),
        .cfg_wdata     (bus_wdata[CFG_W-1:0]),
        .cmd_fresh     (bus_wr && sel_cmd && bus_wdata[1]),
        .flag_wclr     (bus_wr && sel_stat && bus_wdata[0]),
        .go_accept     (go_accept),
        .data_rd_acc   (acc_rd),
        .data_wr_acc   (acc_wr),
        .launch        (launch),
        .finish        (finish),
        .cfg           (cfg),
        .done_flag     (done_flag_o),
        .fresh_pending (fresh_pending)
    );

    cfe_word_buffer #(
        .WORD_W    (WORD_W),
        .NUM_WORDS (NUM_WORDS)
    ) u_buf (
        .clk         (clk),
        .rst_n       (rst_n),
        .ptr_we      (bus_wr && sel_ptr),
        .ptr_wdata   (bus_wdata[PTR_W-1:0]),
        .acc_rd      (acc_rd),
        .acc_wr      (acc_wr),
        .wdata       (bus_wdata),
        .count_en    (count_en),
        .count_clear ((bus_wr && sel_ptr) || launch),
        .load_result (capture),
        .result      (core_block_out),
        .rd_word     (rd_word),
        .ptr         (ptr),
        .block       (core_block_in),
        .fill_done   (fill_done)
    );

    cfe_seq_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_req (go_accept || fill_done),
        .core_done (core_done),
        .busy      (busy),
        .launch    (launch),
        .capture   (capture),
        .finish    (finish)
    );

    // Write-only initialization vector words
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_WORDS; i++) begin
                iv_mem[i] <= '0;
            end
        end else if (bus_wr) begin
            for (int i = 0; i < NUM_WORDS; i++) begin
                if (bus_addr == ADDR_W'(ADR_IV_BASE + i)) begin
                    iv_mem[i] <= bus_wdata;
                end
            end
        end
    end

    generate
        for (genvar g = 0; g < NUM_WORDS; g++) begin : g_iv
            assign core_iv[g*WORD_W +: WORD_W] = iv_mem[g];
        end
    endgenerate

    always_comb begin
        bus_rdata = '0;
        if (sel_cfg) begin
            bus_rdata = {{(WORD_W-CFG_W){1'b0}}, cfg};
        end else if (sel_stat) begin
            bus_rdata = {{(WORD_W-2){1'b0}}, busy, done_flag_o};
        end else if (sel_ptr) begin
            bus_rdata = {{(WORD_W-PTR_W){1'b0}}, ptr};
        end else if (sel_data && !busy) begin
            bus_rdata = rd_word;
        end
    end

    assign busy_o       = busy;
    assign core_req     = launch;
    assign core_use_iv  = launch && fresh_pending;
    assign core_decrypt = cfg.decrypt;
    assign core_mode    = cfg.mode;
    assign core_keysz   = cfg.keysz;

endmodule

// File: rtl/cfe_checker.sv
module cfe_checker #(
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_rdata,
    input logic              busy_o,
    input logic              done_flag_o,
    input logic              core_req,
    input logic              core_done,
    input logic              cfg_enable,
    input logic [2:0]        core_mode,
    input logic [1:0]        core_keysz,
    input logic              core_decrypt
);

    // R3
    busy_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ADDR_W'(4) && busy_o) |-> (bus_rdata == 32'd0));

    // R11
    req_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_req |=> !core_req);

    // R11
    req_from_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_req |-> (busy_o && !$past(busy_o)));

    // R9
    flag_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_flag_o) |-> $past(core_done, 2));

    // R7
    cfg_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_enable && $past(cfg_enable)) |->
            ($stable(core_mode) && $stable(core_keysz) && $stable(core_decrypt)));

endmodule

bind cipher_frontend cfe_checker #(.ADDR_W(ADDR_W)) u_cfe_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_rd       (bus_rd),
    .bus_addr     (bus_addr),
    .bus_rdata    (bus_rdata),
    .busy_o       (busy_o),
    .done_flag_o  (done_flag_o),
    .core_req     (core_req),
    .core_done    (core_done),
    .cfg_enable   (cfg_enable),
    .core_mode    (core_mode),
    .core_keysz   (core_keysz),
    .core_decrypt (core_decrypt)
);

// File: tb/tb_cipher_frontend.sv
`timescale 1ns/1ps
module tb_cipher_frontend;

    localparam int LAT = 24;
    localparam logic [3:0] A_CFG = 4'd0, A_CMD = 4'd1, A_STAT = 4'd2,
                           A_PTR = 4'd3, A_DATA = 4'd4, A_IV = 4'd8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_wr = 1'b0, bus_rd = 1'b0;
    logic [3:0]   bus_addr = '0;
    logic [31:0]  bus_wdata = '0, bus_rdata;
    logic         busy_o, done_flag_o, core_req, core_use_iv, core_decrypt;
    logic [2:0]   core_mode;
    logic [1:0]   core_keysz;
    logic [127:0] core_block_in, core_iv;
    logic         core_done = 1'b0;
    logic [127:0] core_block_out = '0;

    int vecs = 0, errs = 0, req_count = 0;
    logic [127:0] cap_in, cap_iv;
    logic         cap_use;

    always #4 clk = ~clk;

    cipher_frontend dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .busy_o(busy_o), .done_flag_o(done_flag_o), .core_req(core_req),
        .core_use_iv(core_use_iv), .core_decrypt(core_decrypt),
        .core_mode(core_mode), .core_keysz(core_keysz),
        .core_block_in(core_block_in), .core_iv(core_iv),
        .core_done(core_done), .core_block_out(core_block_out)
    );

    function automatic logic [127:0] xform(input logic [127:0] blk, input logic [127:0] iv,
                                           input logic use_iv, input logic [5:0] tag);
        logic [127:0] r;
        for (int i = 0; i < 4; i++) begin
            logic [31:0] w;
            w = blk[i*32 +: 32] ^ (use_iv ? iv[i*32 +: 32] : 32'd0);
            r[i*32 +: 32] = (w ^ 32'h9E37_79B9) + 32'(i) + (32'(tag) << 8);
        end
        return r;
    endfunction

    function automatic logic [31:0] cfgv(input logic en, input logic au, input logic lo,
                                         input logic de, input logic [2:0] mo, input logic [1:0] ks);
        return {23'd0, ks, mo, de, lo, au, en};
    endfunction

    // Abstract core: fixed latency transform
    initial begin
        forever begin
            @(negedge clk);
            if (core_req) begin
                req_count++;
                cap_in  = core_block_in;
                cap_iv  = core_iv;
                cap_use = core_use_iv;
                repeat (LAT) @(negedge clk);
                core_block_out = xform(cap_in, cap_iv, cap_use,
                                       {core_keysz, core_mode, core_decrypt});
                core_done = 1'b1;
                @(negedge clk);
                core_done = 1'b0;
            end
        end
    end

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        vecs++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic set_cfg(input logic [31:0] v);
        wr(A_CFG, 32'd0);
        wr(A_CFG, v);
    endtask

    task automatic wait_done();
        logic [31:0] s;
        for (int n = 0; n < 400; n++) begin
            rd(A_STAT, s);
            if (s[0]) return;
        end
        chk("R9 completion timeout", 0, 1);
    endtask

    task automatic load_block(input logic [127:0] b);
        wr(A_PTR, 32'd0);
        for (int k = 0; k < 4; k++) wr(A_DATA, b[k*32 +: 32]);
    endtask

    task automatic read_block(input string req, input logic [127:0] exp);
        logic [31:0] v;
        wr(A_PTR, 32'd0);
        for (int k = 0; k < 4; k++) begin
            rd(A_DATA, v);
            chk(req, v, exp[k*32 +: 32]);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errs++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

    initial begin
        logic [31:0]  v;
        logic [127:0] blk, exp, ivb, prev;
        int           reqs;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(A_CFG, v);  chk("R1 config", v, 0);
        rd(A_STAT, v); chk("R1 status", v, 0);
        rd(A_PTR, v);  chk("R1 pointer", v, 0);
        for (int k = 0; k < 4; k++) begin
            rd(A_DATA, v); chk("R1 data word", v, 0);
        end

        // R4 start ignored while disabled
        wr(A_CMD, 32'd1);
        repeat (3) @(negedge clk);
        rd(A_STAT, v); chk("R4 go while disabled", v, 0);
        chk("R4 no request while disabled", req_count, 0);

        // R2 pointer sweep from every start position
        for (int p = 0; p < 4; p++) begin
            wr(A_PTR, 32'(p));
            rd(A_PTR, v); chk("R2 pointer load", v, p);
            for (int k = 0; k < 4; k++) wr(A_DATA, 32'hA000_0000 + 32'(p*16 + k));
            rd(A_PTR, v); chk("R2 pointer wrap", v, p);
            wr(A_PTR, 32'd0);
            for (int k = 0; k < 4; k++) begin
                rd(A_DATA, v);
                chk("R2 word placement", v, 32'hA000_0000 + 32'(p*16 + ((k - p + 4) % 4)));
            end
        end

        // R7 config lock
        wr(A_CFG, cfgv(1, 0, 0, 0, 3'd3, 2'd1));
        wr(A_CFG, cfgv(1, 1, 1, 1, 3'd5, 2'd2));
        rd(A_CFG, v); chk("R7 locked while enabled", v, cfgv(1, 0, 0, 0, 3'd3, 2'd1));
        wr(A_CFG, 32'd0);
        rd(A_CFG, v); chk("R7 only enable clears", v, cfgv(0, 0, 0, 0, 3'd3, 2'd1));
        wr(A_CFG, cfgv(0, 0, 1, 1, 3'd6, 2'd2));
        rd(A_CFG, v); chk("R7 full write when disabled", v, cfgv(0, 0, 1, 1, 3'd6, 2'd2));

        // Manual runs across every mode value
        for (int m = 0; m < 8; m++) begin
            logic [31:0] c;
            c = cfgv(1, 0, 0, m[0], 3'(m), 2'(m % 3));
            set_cfg(c);
            for (int k = 0; k < 4; k++) blk[k*32 +: 32] = 32'h1000_0000 * 32'(m + 1) + 32'(k * 'h111);
            load_block(blk);
            reqs = req_count;
            wr(A_CMD, 32'd1);
            rd(A_STAT, v); chk("R9 busy and flag cleared by go", v, 2);
            rd(A_DATA, v); chk("R3 read while busy", v, 0);
            wr(A_DATA, 32'hDEAD_BEEF);
            rd(A_PTR, v); chk("R3 pointer held while busy", v, 0);
            wait_done();
            chk("R11 one request", req_count, reqs + 1);
            chk("R11 block to core", cap_in, blk);
            chk("R8 no IV without marker", cap_use, 0);
            exp = xform(blk, '0, 1'b0, c[8:3]);
            read_block("R6 result replaces buffer", exp);
            rd(A_STAT, v); chk("R10 data read clears flag", v, 0);
        end

        // R8 IV marker, one block only
        set_cfg(cfgv(1, 0, 0, 0, 3'd2, 2'd0));
        for (int k = 0; k < 4; k++) begin
            ivb[k*32 +: 32] = 32'h0F0F_0000 + 32'(k);
            wr(A_IV + 4'(k), ivb[k*32 +: 32]);
        end
        rd(A_IV, v); chk("R8 IV reads zero", v, 0);
        blk = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210;
        load_block(blk);
        wr(A_CMD, 32'd3);
        wait_done();
        chk("R8 marker on first block", cap_use, 1);
        prev = xform(blk, ivb, 1'b1, {2'd0, 3'd2, 1'b0});
        chk("R8 IV applied", cap_iv, ivb);
        wr(A_CMD, 32'd1);
        wait_done();
        chk("R8 marker cleared", cap_use, 0);
        read_block("R8 chained result", xform(prev, ivb, 1'b0, {2'd0, 3'd2, 1'b0}));

        // R9 write-1 clear
        wr(A_CMD, 32'd1);
        wait_done();
        wr(A_STAT, 32'd1);
        rd(A_STAT, v); chk("R9 write one clears flag", v, 0);

        // R10 last-output mode
        set_cfg(cfgv(1, 0, 1, 0, 3'd1, 2'd0));
        load_block(blk);
        wr(A_CMD, 32'd1);
        wait_done();
        rd(A_DATA, v);
        rd(A_STAT, v); chk("R10 read keeps flag", v, 1);
        wr(A_DATA, 32'h5);
        rd(A_STAT, v); chk("R10 write clears flag", v, 0);

        // R5 automatic start
        set_cfg(cfgv(1, 1, 0, 0, 3'd4, 2'd2));
        reqs = req_count;
        wr(A_CMD, 32'd1);
        repeat (3) @(negedge clk);
        rd(A_STAT, v); chk("R4 go ignored in auto mode", v, 0);
        wr(A_PTR, 32'd0);
        for (int k = 0; k < 3; k++) wr(A_DATA, 32'hB000_0000 + 32'(k));
        rd(A_STAT, v); chk("R5 idle after three words", v, 0);
        wr(A_PTR, 32'd1);
        for (int k = 0; k < 3; k++) wr(A_DATA, 32'hC000_0000 + 32'(k));
        rd(A_STAT, v); chk("R5 count reset by pointer write", v, 0);
        wr(A_DATA, 32'hC000_0003);
        rd(A_STAT, v); chk("R5 start on fourth word", v, 2);
        wait_done();
        chk("R5 single auto request", req_count, reqs + 1);
        for (int k = 0; k < 4; k++) blk[((1 + k) % 4)*32 +: 32] = 32'hC000_0000 + 32'(k);
        chk("R11 auto block to core", cap_in, blk);
        read_block("R6 auto result", xform(blk, '0, 1'b0, {2'd2, 3'd4, 1'b0}));

        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

endmodule